// File: doc/BRIEF.md
# Variable-Segment Carry-Select Adder

This block is a 32-bit combinational adder. It forms the final binary result from the pair of vectors left by a carry-save multiplier array. An example is a multiplier that handles both integer and binary-field products. The two operands and a carry-in go in. A 32-bit sum and a carry-out come out, in the same cycle, with no clock and no state.

The operand bits are divided into seven segments. Their widths grow toward the most significant end, so that each later segment has about as much time as the select carry takes to reach it. Each segment has two ripple chains of one-bit cells. One chain assumes that no carry enters the segment, and the other assumes that a carry does. The real carry from the segment below then picks one sum and one carry-out through 2:1 multiplexers. Every addition is built from these cells; no arithmetic operator is used anywhere.

Top module: `csel_adder32`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) mod 2^32 for every input combination.
- R2: `carry_out` equals bit 32 of the full 33-bit result of `op_a` + `op_b` + `carry_in`.
- R3: The segments span bits [1:0], [4:2], [8:5], [13:9], [18:14], [24:19] and [31:25]. A carry that is generated just below each lower edge (bit positions 2, 5, 9, 14, 19, 25 and 32) reaches the segment above and sets the result bit at that position.
- R4: Inside every segment, if the chain that assumes an incoming carry of 0 produces a carry-out, then the chain that assumes an incoming carry of 1 also produces one.
- R5: Inside every segment, the two speculative carry-outs differ only when the carry-0 sum is all ones and the carry-1 sum is all zeros.
- R6: All-ones plus all-ones with `carry_in` = 1 gives `sum` = 0xFFFFFFFF and `carry_out` = 1.
- R7: When `op_b` is the bitwise complement of `op_a`, the result is 0xFFFFFFFF with `carry_out` = 0 when `carry_in` = 0, and 0 with `carry_out` = 1 when `carry_in` = 1.
- R8: With both operands zero, `sum` equals `carry_in` and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First addend, for example the sum vector of a carry-save array |
| op_b | input | 32 | Second addend, for example the shifted carry vector |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the result |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
The hardest case to reach from the ports is a carry that has to cross a segment edge and then run through a whole segment of propagate bits. Random operands seldom make a long propagate run, so the select multiplexer that follows such a run is rarely exercised. The bench adds directed vectors for each edge position. One set is a block of ones below the edge plus a carry-in. The other is a pair of generate bits placed just under the edge. The complement-operand vectors make every bit propagate, so a single carry-in has to cross all seven segments.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int NUM_SEG = 7;
    // Segment widths from the least significant end; order sets the layout.
    localparam int SEG_W [NUM_SEG] = '{2, 3, 4, 5, 5, 6, 7};

    // Lowest bit position occupied by segment k.
    function automatic int seg_lo(input int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) begin
            acc = acc + SEG_W[i];
        end
        return acc;
    endfunction

    localparam int SUM_W = seg_lo(NUM_SEG);

    typedef struct packed {
        logic             carry;
        logic [SUM_W-1:0] bits;
    } add_result_t;

endpackage

// File: rtl/csel_bit_cell.sv
module csel_bit_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic eqv;
    logic gen_n;
    logic prop_n;

    assign eqv    = ~(x ^ y);
    assign s      = ~(eqv ^ ci);
    assign gen_n  = ~(x & y);
    assign prop_n = ~((~eqv) & ci);
    assign co     = ~(gen_n & prop_n);
endmodule

// File: rtl/csel_ripple_chain.sv
module csel_ripple_chain #(
    parameter int W        = 4,
    parameter bit CARRY_IN = 1'b0
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = CARRY_IN;

    for (genvar i = 0; i < W; i++) begin : g_cell
        csel_bit_cell u_cell (
            .x  (x[i]),
            .y  (y[i]),
            .ci (c[i]),
            .s  (s[i]),
            .co (c[i+1])
        );
    end

    assign co = c[W];
endmodule

// File: rtl/csel_segment.sv
module csel_segment #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] s_if0;
    logic [W-1:0] s_if1;
    logic         co_if0;
    logic         co_if1;

    csel_ripple_chain #(.W(W), .CARRY_IN(1'b0)) u_chain0 (
        .x (x), .y (y), .s (s_if0), .co (co_if0)
    );

    csel_ripple_chain #(.W(W), .CARRY_IN(1'b1)) u_chain1 (
        .x (x), .y (y), .s (s_if1), .co (co_if1)
    );

    assign s  = ci ? s_if1  : s_if0;
    assign co = ci ? co_if1 : co_if0;

    always_comb begin
        // R4: a carry-in of 1 can never remove a carry-out
        assert_carry_monotone_R4: assert (!(co_if0 && !co_if1))
            else $error("segment carry-0 chain carries out while carry-1 chain does not");
        // R5: speculative carries differ only on a full propagate run
        assert_split_carry_R5: assert (!(co_if0 != co_if1) || ((&s_if0) && !(|s_if1)))
            else $error("speculative carries differ without an all-propagate segment");
    end
endmodule

// File: rtl/csel_adder32.sv
module csel_adder32
    import csel_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        carry_in,
    output logic [31:0] sum,
    output logic        carry_out
);
    logic [NUM_SEG:0] seg_c;
    add_result_t      res;

    assign seg_c[0] = carry_in;

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        localparam int LO = seg_lo(k);
        localparam int WK = SEG_W[k];

        csel_segment #(.W(WK)) u_seg (
            .x  (op_a[LO +: WK]),
            .y  (op_b[LO +: WK]),
            .ci (seg_c[k]),
            .s  (res.bits[LO +: WK]),
            .co (seg_c[k+1])
        );
    end

    assign res.carry = seg_c[NUM_SEG];
    assign sum       = res.bits;
    assign carry_out = res.carry;

    always_comb begin
        // R1: bit 0 depends only on the three bits entering the lowest cell
        assert_lsb_parity_R1: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in))
            else $error("least significant sum bit wrong");
        // R7: complementary operands pass carry_in straight to carry_out
        assert_full_propagate_R7: assert (!(op_a == ~op_b) || (carry_out == carry_in))
            else $error("complement operands did not forward carry_in");
        // R8: zero operands give a result equal to carry_in
        assert_zero_operands_R8: assert (!((op_a == '0) && (op_b == '0))
                                         || ((sum == {31'd0, carry_in}) && !carry_out))
            else $error("zero operands gave a wrong result");
    end
endmodule

// File: tb/test_csel_adder32.sv
module test_csel_adder32;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        ci;
        logic [31:0] exp_sum;
        logic        exp_co;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R8
        '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0}, // R8
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1}, // R6
        '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1}, // R2
        '{32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0}, // R1
        '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, 32'hFFFF_FFFF, 1'b0}, // R7
        '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b1, 32'h0000_0000, 1'b1}, // R7
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R2
        '{32'h0000_0003, 32'h0000_0001, 1'b0, 32'h0000_0004, 1'b0}, // R3
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0}  // R1
    };

    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] sum;
    logic        carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    csel_adder32 i_csel_adder32 (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out)
    );

    task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input logic ci,
                           input logic [31:0] es, input logic eco, input string req);
        @(posedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = ci;
        @(negedge clk);
        n_checks++;
        if (sum !== es || carry_out !== eco) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h ci=%0d: got sum=%h co=%0d, expected sum=%h co=%0d",
                     req, a, b, ci, sum, carry_out, es, eco);
        end
    endtask

    task automatic run_ref(input logic [31:0] a, input logic [31:0] b, input logic ci,
                           input string req);
        logic [32:0] r;
        r = {1'b0, a} + {1'b0, b} + {32'd0, ci};
        run_vec(a, b, ci, r[31:0], r[32], req);
    endtask

    initial begin
        // Zero inputs: the initial state of the outputs (R8)
        run_vec('0, '0, 1'b0, '0, 1'b0, "R8");

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i].a, VECS[i].b, VECS[i].ci, VECS[i].exp_sum, VECS[i].exp_co, "R1/R2 table");
        end

        // R3: carries reaching each segment edge
        foreach (csel_pkg::SEG_W[k]) begin
            int p;
            logic [32:0] ones;
            logic [32:0] top;
            p    = csel_pkg::seg_lo(k + 1);
            ones = (33'd1 << p) - 33'd1;
            top  = 33'd1 << p;
            run_vec(ones[31:0], 32'd0, 1'b1, top[31:0], top[32], "R3 propagate edge");
            run_vec(32'h1 << (p - 1), 32'h1 << (p - 1), 1'b0, top[31:0], top[32], "R3 generate edge");
        end

        // R7: complement operands, carry crossing all segments
        run_vec(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1, "R7");
        run_vec(32'hC3A5_0F96, 32'h3C5A_F069, 1'b0, 32'hFFFF_FFFF, 1'b0, "R7");

        // R1 R2 random vectors; R4 R5 are observed by the in-segment assertions
        for (int i = 0; i < 3000; i++) begin
            run_ref($urandom, $urandom, 1'($urandom), "R1/R2 random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule